// File: doc/BRIEF.md
# Interrupt Router Register Window

This block is the bus-facing register front end of an interrupt router. Software sees only two registers: an 8-bit select register and a 32-bit data window. The select value picks an internal register behind the window. That register can be the router's 4-bit unit ID, a read-only version word, or one 32-bit half of a 64-bit routing entry. There is one routing entry per interrupt input pin.

The separate delivery engine reads the whole routing table on a flat output. It can also set an entry's remote-IRR status flag through a per-pin set input. Whenever the bus completes a window write to an entry, the block pulses a notice that carries the entry index, so the engine can re-examine that entry.

An access is one cycle with `req_i` high. Read data appears on `rdata_o` in the following cycle and holds until the next read. Routing entry layout:
- vector: bits 7:0
- delivery mode: bits 10:8
- destination mode: bit 11
- polarity: bit 13
- remote IRR: bit 14
- trigger mode: bit 15
- mask: bit 16
- destination ID: bits 63:56

Top module: `irq_regwin`

## Requirements
- R1: A write to offset 0x00 stores bits 7:0 of the write data in the select register. A read of offset 0x00 returns the select value zero-extended.
- R2: With select 1, a window read (offset 0x10) returns NUM_PINS-1 in bits 23:16 and VERSION in bits 7:0, with all other bits zero.
- R3: A window write with select 0 loads the unit ID from data bits 27:24. Window reads with select 0 or select 2 return the ID in bits 27:24 and zero elsewhere. Window writes with select 1 or select 2 change nothing.
- R4: For select >= 0x10 the entry number is (select-0x10)>>1. An even select reaches entry bits 31:0 and an odd select reaches entry bits 63:32.
- R5: A select that reaches no existing entry (an entry number >= NUM_PINS, or select 0x03 to 0x0F) reads back 0xFFFFFFFF through the window. A write with such a select is dropped and raises no update pulse.
- R6: A lower-half write always clears remote IRR (bit 14), whatever the data. An upper-half write leaves it as it was. `irr_set_i[n]` sets bit 14 of entry n unless entry n receives a lower-half write in the same cycle.
- R7: Only address bits 7:0 are decoded. Any offset other than 0x00 and 0x10 reads zero, and a write to it has no effect.
- R8: A write length of 1 or 2 bytes zero-extends data bits 7:0 or 15:0. A length of 4 or 8 uses bits 31:0. Any other length drops the write.
- R9: After reset, every entry is 0x0000_0000_0001_0000 (only the mask bit set), and both the select register and the unit ID are zero.
- R10: A completed entry write raises `upd_o` for exactly one cycle, with `upd_idx_o` holding the entry number. The new entry value is visible on `entries_o` in that same cycle.
- R11: `rdata_o` updates in the cycle after a read request and holds its value through writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address; bits 7:0 decoded |
| len_i | input | 4 | Access length in bytes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irr_set_i | input | NUM_PINS | Remote-IRR set requests from the delivery engine |
| entries_o | output | NUM_PINS*64 | Routing table, entry n at bits n*64 +: 64 |
| upd_o | output | 1 | Entry-written pulse |
| upd_idx_o | output | $clog2(NUM_PINS) | Index of the written entry |

## Verification
The assertions assume that `req_i`, `we_i`, `addr_i`, `len_i` and `wdata_i` are known and settled at every rising edge, and that `irr_set_i` is a single-cycle request. The bench meets this by changing every input only on falling edges, pulsing each request for one cycle and returning all strobes to zero between accesses. The assertions also expect that an upper-half write never lands on an entry in the same cycle as a set request for that entry. The stimulus never raises `irr_set_i` during a bus access.

// File: rtl/irq_regwin_pkg.sv
package irq_regwin_pkg;
  localparam logic [7:0] OFF_SEL   = 8'h00;
  localparam logic [7:0] OFF_WIN   = 8'h10;
  localparam logic [7:0] IDX_ID    = 8'h00;
  localparam logic [7:0] IDX_VER   = 8'h01;
  localparam logic [7:0] IDX_ARB   = 8'h02;
  localparam logic [7:0] IDX_TBL   = 8'h10;
  localparam int         RIRR_BIT  = 14;
  localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;

  function automatic logic [31:0] size_data(input logic [3:0] len, input logic [31:0] d);
    case (len)
      4'd1:    size_data = {24'h0, d[7:0]};
      4'd2:    size_data = {16'h0, d[15:0]};
      default: size_data = d;
    endcase
  endfunction
endpackage

// File: rtl/irq_regwin_decode.sv
module irq_regwin_decode
  import irq_regwin_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int ADDR_W   = 16,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        len_i,
  input  logic [31:0]       wdata_i,
  input  logic [7:0]        sel_i,
  output logic              is_sel_o,
  output logic              is_win_o,
  output logic              len_ok_o,
  output logic [31:0]       data_o,
  output logic              ent_ok_o,
  output logic              ent_hi_o,
  output logic [IDX_W-1:0]  ent_idx_o
);
  logic [7:0] off;
  logic [7:0] diff;
  logic [6:0] idx7;

  assign off      = addr_i[7:0];
  assign is_sel_o = (off == OFF_SEL);
  assign is_win_o = (off == OFF_WIN);
  assign len_ok_o = (len_i == 4'd1) || (len_i == 4'd2) || (len_i == 4'd4) || (len_i == 4'd8);
  assign data_o   = size_data(len_i, wdata_i);

  assign diff      = sel_i - IDX_TBL;
  assign idx7      = diff[7:1];
  assign ent_hi_o  = sel_i[0];
  assign ent_ok_o  = (sel_i >= IDX_TBL) && (int'(idx7) < NUM_PINS);
  assign ent_idx_o = idx7[IDX_W-1:0];
endmodule

// File: rtl/irq_regwin_table.sv
module irq_regwin_table
  import irq_regwin_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic                      wr_hi_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  logic [31:0]               wr_data_i,
  input  logic [NUM_PINS-1:0]       irr_set_i,
  output logic [NUM_PINS-1:0][63:0] ent_o
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
    logic hit, wr_lo, wr_hi;
    assign hit   = wr_en_i && (wr_idx_i == IDX_W'(i));
    assign wr_lo = hit && !wr_hi_i;
    assign wr_hi = hit && wr_hi_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_o[i] <= ENTRY_RST;
      end else if (wr_lo) begin
        ent_o[i][31:0]     <= wr_data_i;
        ent_o[i][RIRR_BIT] <= 1'b0;
      end else begin
        if (wr_hi) ent_o[i][63:32] <= wr_data_i;
        if (irr_set_i[i]) ent_o[i][RIRR_BIT] <= 1'b1;
      end
    end

    assert_rirr_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_lo |=> !ent_o[i][RIRR_BIT]);
    assert_rirr_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irr_set_i[i] && !wr_lo) |=> ent_o[i][RIRR_BIT]);
    assert_hi_keeps_lo_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_hi && !irr_set_i[i]) |=> $stable(ent_o[i][31:0]));
  end
endmodule

// File: rtl/irq_regwin.sv
module irq_regwin
  import irq_regwin_pkg::*;
#(
  parameter int         NUM_PINS = 24,
  parameter int         ADDR_W   = 16,
  parameter logic [7:0] VERSION  = 8'h11,
  localparam int        IDX_W    = $clog2(NUM_PINS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [3:0]              len_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  input  logic [NUM_PINS-1:0]     irr_set_i,
  output logic [NUM_PINS*64-1:0]  entries_o,
  output logic                    upd_o,
  output logic [IDX_W-1:0]        upd_idx_o
);
  localparam logic [7:0] LAST_IDX = 8'(NUM_PINS - 1);

  logic [7:0]              sel_q;
  logic [3:0]              id_q;
  logic                    is_sel, is_win, len_ok, ent_ok, ent_hi;
  logic [31:0]             data;
  logic [IDX_W-1:0]        ent_idx;
  logic                    wr_ok, tbl_wr;
  logic [NUM_PINS-1:0][63:0] ent;
  logic [63:0]             cur_ent;
  logic [31:0]             win_rd, rd_val;

  irq_regwin_decode #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_dec (
    .addr_i(addr_i), .len_i(len_i), .wdata_i(wdata_i), .sel_i(sel_q),
    .is_sel_o(is_sel), .is_win_o(is_win), .len_ok_o(len_ok), .data_o(data),
    .ent_ok_o(ent_ok), .ent_hi_o(ent_hi), .ent_idx_o(ent_idx)
  );

  assign wr_ok  = req_i && we_i && len_ok;
  assign tbl_wr = wr_ok && is_win && ent_ok;

  irq_regwin_table #(.NUM_PINS(NUM_PINS)) u_tbl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(tbl_wr), .wr_hi_i(ent_hi),
    .wr_idx_i(ent_idx), .wr_data_i(data), .irr_set_i(irr_set_i), .ent_o(ent)
  );

  assign entries_o = ent;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (wr_ok && is_sel) sel_q <= data[7:0];
      if (wr_ok && is_win && sel_q == IDX_ID) id_q <= data[27:24];
    end
  end

  assign cur_ent = ent_ok ? ent[ent_idx] : '1;

  always_comb begin
    if (sel_q == IDX_ID || sel_q == IDX_ARB) win_rd = {4'h0, id_q, 24'h0};
    else if (sel_q == IDX_VER)               win_rd = {8'h0, LAST_IDX, 8'h0, VERSION};
    else if (ent_hi)                         win_rd = cur_ent[63:32];
    else                                     win_rd = cur_ent[31:0];
  end

  always_comb begin
    if (is_sel)      rd_val = {24'h0, sel_q};
    else if (is_win) rd_val = win_rd;
    else             rd_val = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o   <= '0;
      upd_o     <= 1'b0;
      upd_idx_o <= '0;
    end else begin
      if (req_i && !we_i) rdata_o <= rd_val;
      upd_o <= tbl_wr;
      if (tbl_wr) upd_idx_o <= ent_idx;
    end
  end

  assert_sel_store_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && len_i == 4'd4 && addr_i[7:0] == OFF_SEL) |=> sel_q == $past(wdata_i[7:0]));
  assert_bad_off_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !is_sel && !is_win) |=> rdata_o == 32'h0);
  assert_oor_no_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && is_win && !ent_ok) |=> !upd_o);
  assert_upd_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_wr |=> (upd_o && upd_idx_o == $past(ent_idx)));
  assert_rdata_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));
  assert_bad_len_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !len_ok) |=> (!upd_o && $stable(sel_q) && $stable(id_q)));
endmodule

// File: tb/irq_regwin_tb_top.sv
module irq_regwin_tb_top;
  localparam int NP = 24;
  localparam int IW = $clog2(NP);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0, we = 1'b0;
  logic [15:0]       addr = '0;
  logic [3:0]        len = 4'd4;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NP-1:0]     irr_set = '0;
  logic [NP*64-1:0]  entries;
  logic              upd;
  logic [IW-1:0]     upd_idx;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_regwin #(.NUM_PINS(NP), .ADDR_W(16), .VERSION(8'h11)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .len_i(len), .wdata_i(wdata), .rdata_o(rdata), .irr_set_i(irr_set),
    .entries_o(entries), .upd_o(upd), .upd_idx_o(upd_idx)
  );

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [3:0] l, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; len = l; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; len = 4'd4;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic win_rd(input logic [7:0] s, output logic [31:0] d);
    wr(16'h0000, 4'd4, {24'h0, s});
    rd(16'h0010, d);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(16'h0000, d);        chk("R9 select", d, 0);
    rd(16'h0010, d);        chk("R9 id", d, 0);
    win_rd(8'h10, d);       chk("R9 entry0 lo", d, 32'h0001_0000);
    win_rd(8'h11, d);       chk("R9 entry0 hi", d, 0);
    win_rd(8'h3E, d);       chk("R9 entry23 lo", d, 32'h0001_0000);
  endtask

  task automatic t_select;
    logic [31:0] d;
    wr(16'h0000, 4'd4, 32'h0000_01A5);
    rd(16'h0000, d);        chk("R1 low byte", d, 32'hA5);
    wr(16'h0300, 4'd4, 32'h0000_0033);
    rd(16'h0000, d);        chk("R7 alias select", d, 32'h33);
    wr(16'h0000, 4'd4, 32'h0000_0077);
    chk("R11 rdata hold", rdata, 32'h33);
  endtask

  task automatic t_ver_id;
    logic [31:0] d;
    win_rd(8'h01, d);       chk("R2 version", d, 32'h0017_0011);
    wr(16'h0010, 4'd4, 32'hFFFF_FFFF);
    rd(16'h0010, d);        chk("R2 version write ignored", d, 32'h0017_0011);
    wr(16'h0000, 4'd4, 32'h0);
    wr(16'h0010, 4'd4, 32'hFA00_0000);
    rd(16'h0010, d);        chk("R3 id sel0", d, 32'h0A00_0000);
    wr(16'h0000, 4'd4, 32'h2);
    wr(16'h0010, 4'd4, 32'h0500_0000);
    rd(16'h0010, d);        chk("R3 id sel2 write ignored", d, 32'h0A00_0000);
  endtask

  task automatic t_entry;
    logic [31:0] d;
    wr(16'h0000, 4'd4, 32'h1A);
    wr(16'h0010, 4'd4, 32'h0000_80B3);
    chk("R10 pulse", {63'h0, upd}, 1);
    chk("R10 idx", {{(64-IW){1'b0}}, upd_idx}, 5);
    chk("R10 visible", entries[5*64 +: 32], 32'h0000_80B3);
    @(negedge clk);
    chk("R10 one cycle", {63'h0, upd}, 0);
    wr(16'h0000, 4'd4, 32'h1B);
    wr(16'h0010, 4'd4, 32'hC100_0000);
    rd(16'h0010, d);        chk("R4 odd hi", d, 32'hC100_0000);
    win_rd(8'h1A, d);       chk("R4 even lo", d, 32'h0000_80B3);
    chk("R4 entry5", entries[5*64 +: 64], 64'hC100_0000_0000_80B3);
  endtask

  task automatic t_oor;
    logic [31:0] d;
    win_rd(8'h40, d);       chk("R5 oor read", d, 32'hFFFF_FFFF);
    win_rd(8'h05, d);       chk("R5 gap read", d, 32'hFFFF_FFFF);
    wr(16'h0000, 4'd4, 32'h41);
    wr(16'h0010, 4'd4, 32'h1234_5678);
    chk("R5 oor no pulse", {63'h0, upd}, 0);
    chk("R5 entry23 intact", entries[23*64 +: 64], 64'h0000_0000_0001_0000);
  endtask

  task automatic t_rirr;
    logic [31:0] d;
    @(negedge clk); irr_set = 24'h000008;
    @(negedge clk); irr_set = '0;
    win_rd(8'h16, d);       chk("R6 set", d, 32'h0001_4000);
    wr(16'h0000, 4'd4, 32'h17);
    wr(16'h0010, 4'd4, 32'h1100_0000);
    win_rd(8'h16, d);       chk("R6 hi keeps", d, 32'h0001_4000);
    wr(16'h0010, 4'd4, 32'h0000_4022);
    rd(16'h0010, d);        chk("R6 lo clears", d, 32'h0000_0022);
  endtask

  task automatic t_offsets;
    logic [31:0] d;
    wr(16'h0000, 4'd4, 32'h10);
    wr(16'h0020, 4'd4, 32'h9999_9999);
    chk("R7 bad off no pulse", {63'h0, upd}, 0);
    rd(16'h0020, d);        chk("R7 bad off read", d, 0);
    rd(16'h0004, d);        chk("R7 off4 read", d, 0);
    rd(16'h0000, d);        chk("R7 select kept", d, 32'h10);
  endtask

  task automatic t_lengths;
    logic [31:0] d;
    wr(16'h0000, 4'd4, 32'h18);
    wr(16'h0010, 4'd1, 32'hDEAD_BEEF);
    rd(16'h0010, d);        chk("R8 len1", d, 32'hEF);
    wr(16'h0010, 4'd2, 32'hDEAD_BEEF);
    rd(16'h0010, d);        chk("R8 len2", d, 32'hBEEF);
    wr(16'h0010, 4'd8, 32'hDEAD_BEEF);
    rd(16'h0010, d);        chk("R8 len8", d, 32'hDEAD_BEEF);
    wr(16'h0010, 4'd3, 32'h1234_5678);
    chk("R8 len3 no pulse", {63'h0, upd}, 0);
    rd(16'h0010, d);        chk("R8 len3 dropped", d, 32'hDEAD_BEEF);
    wr(16'h0000, 4'd1, 32'h0000_1234);
    rd(16'h0000, d);        chk("R8 select len1", d, 32'h34);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_select();
    t_ver_id();
    t_entry();
    t_oor();
    t_rirr();
    t_offsets();
    t_lengths();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule